// File: doc/BRIEF.md
# Flash Command and Result Controller

This block sits between a register interface and an on-chip flash array. Software writes a 32-bit command word; the controller decodes it, updates its lock and general-purpose bit registers, starts page programming when allowed, and prepares answers in a single result register. Software reads that register over and over, and each read moves on to the next word of the current answer. An organization query steps through the identifier, the total size, the page size, the lock-region count and the lock-region size. Lock-status and general-purpose-status queries return a bit vector in word 0.

Every program request is checked against the lock bit of the region that holds the target page. A request for a locked page never reaches the array and raises a sticky lock-error flag instead. The array itself is not modelled: a one-cycle start pulse goes out with the page number, and the controller stays busy until a done input comes back. The size option (128 KB as 8 regions of 64 pages, or 64 KB as 16 regions of 16 pages, with 256-byte pages) is chosen by a parameter.

Top module: `fcmd_ctrl`

## Requirements
- R1: After reset `ready` is 1, `lock_err`, `cmd_err`, `prog_start`, `security_en` and `boot_flash` are 0, `res_word` is 0 and all lock bits are clear.
- R2: Command word layout: code in bits [7:0], argument in bits [23:8], bits [31:24] reserved. After code 0x11 (organization query), successive result reads return the identifier, the flash size in bytes, the page size in bytes, the lock-region count, the lock-region size in bytes, and 0 for every later read. Each pulse of `res_re` advances one word.
- R3: Code 0x08 with a page argument sets the lock bit of region page/PPR, where PPR is 64 for 128 KB and 16 for 64 KB. Code 0x0A makes result word 0 hold the lock bits, with region n in bit n.
- R4: A program command (code 0x01 plain, 0x03 with erase) whose page lies in a locked region gives no `prog_start`, keeps `ready` at 1 and sets `lock_err`.
- R5: A program command to an unlocked page drives `prog_start` high for exactly one cycle, together with `prog_page` equal to the argument and `prog_erase` equal to 1 for code 0x03 and 0 for code 0x01. `ready` stays low from that cycle until the cycle after `prog_done` is seen.
- R6: A command written while `ready` is 0 has no effect on lock bits, general-purpose bits or flags.
- R7: Every accepted command restarts the result read sequence at word 0.
- R8: An unknown code, a nonzero reserved field, a page argument at or beyond the page count, or a bit index at or beyond the bit count sets the sticky `cmd_err` and changes nothing else.
- R9: `lock_err` and `cmd_err` hold until a `stat_re` pulse, which clears them at the next clock edge.
- R10: Code 0x0B sets and code 0x0C clears the general-purpose bit given by the argument. Bit 0 drives `security_en` and bit 1 drives `boot_flash`. Code 0x0D makes result word 0 hold these bits.
- R11: Code 0x09 with a page argument clears the lock bit of the region holding that page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_word | input | 32 | Command code, argument and reserved field |
| res_re | input | 1 | Result read strobe; advances the read sequence |
| res_word | output | 32 | Current result word |
| stat_re | input | 1 | Status read strobe; clears the sticky flags |
| ready | output | 1 | High when a command can be accepted |
| lock_err | output | 1 | Sticky: a program request hit a locked region |
| cmd_err | output | 1 | Sticky: a malformed or unknown command was seen |
| prog_start | output | 1 | One-cycle start pulse to the array |
| prog_erase | output | 1 | The started operation erases the page first |
| prog_page | output | 16 | Page of the started operation |
| prog_done | input | 1 | Array reports the operation finished |
| security_en | output | 1 | General-purpose bit 0 |
| boot_flash | output | 1 | General-purpose bit 1 |

## Verification
A corrupted lock register shows up within one command. The next lock-status query returns the wrong word. A program request to that region then either starts when it should not or is refused with `lock_err` when it should start. A stuck or badly advanced read pointer shows up on the first result read after a command, because word 0 (the identifier or a bit vector) comes back as some other word. A busy state that fails to clear keeps `ready` low for the rest of the run. The bench drives both size options with the same stimulus, so any region-mapping error changes the vectors of the two instances in different ways.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

   localparam int CMD_W   = 32;
   localparam int CODE_W  = 8;
   localparam int ARG_LSB = 8;
   localparam int ARG_W   = 16;
   localparam int RES_W   = 32;

   localparam logic [CODE_W-1:0] C_PROG    = 8'h01;
   localparam logic [CODE_W-1:0] C_EPROG   = 8'h03;
   localparam logic [CODE_W-1:0] C_LOCK    = 8'h08;
   localparam logic [CODE_W-1:0] C_UNLOCK  = 8'h09;
   localparam logic [CODE_W-1:0] C_GETLOCK = 8'h0A;
   localparam logic [CODE_W-1:0] C_GPSET   = 8'h0B;
   localparam logic [CODE_W-1:0] C_GPCLR   = 8'h0C;
   localparam logic [CODE_W-1:0] C_GETGP   = 8'h0D;
   localparam logic [CODE_W-1:0] C_DESC    = 8'h11;

   typedef enum logic [3:0] {
      OP_DESC, OP_PROG, OP_EPROG, OP_LOCK, OP_UNLOCK,
      OP_GETLOCK, OP_GPSET, OP_GPCLR, OP_GETGP, OP_BAD
   } op_t;

   typedef enum logic [1:0] {
      RM_NONE, RM_DESC, RM_LOCK, RM_GP
   } rmode_t;

endpackage

// File: rtl/fcmd_decode.sv
module fcmd_decode
   import fcmd_pkg::*;
#(
   parameter int PAGES    = 512,
   parameter int PPR_LOG2 = 6,
   parameter int REGION_W = 3,
   parameter int GP_BITS  = 2,
   parameter int GPI_W    = 1
) (
   input  logic [CMD_W-1:0]    cmd,
   output op_t                 op,
   output logic                arg_ok,
   output logic [ARG_W-1:0]    arg,
   output logic [REGION_W-1:0] region,
   output logic [GPI_W-1:0]    gp_idx
);

   localparam int RSVD_LSB = ARG_LSB + ARG_W;

   logic [CODE_W-1:0]         code;
   logic [CMD_W-RSVD_LSB-1:0] rsvd;
   logic                      page_in_range;
   logic                      bit_in_range;

   assign code   = cmd[CODE_W-1:0];
   assign arg    = cmd[ARG_LSB +: ARG_W];
   assign rsvd   = cmd[CMD_W-1:RSVD_LSB];
   assign region = REGION_W'(arg >> PPR_LOG2);
   assign gp_idx = GPI_W'(arg);

   assign page_in_range = (32'(arg) < PAGES);
   assign bit_in_range  = (32'(arg) < GP_BITS);

   always_comb begin
      unique case (code)
         C_DESC:    op = OP_DESC;
         C_PROG:    op = OP_PROG;
         C_EPROG:   op = OP_EPROG;
         C_LOCK:    op = OP_LOCK;
         C_UNLOCK:  op = OP_UNLOCK;
         C_GETLOCK: op = OP_GETLOCK;
         C_GPSET:   op = OP_GPSET;
         C_GPCLR:   op = OP_GPCLR;
         C_GETGP:   op = OP_GETGP;
         default:   op = OP_BAD;
      endcase
      if (rsvd != '0) op = OP_BAD;
   end

   always_comb begin
      unique case (op)
         OP_PROG, OP_EPROG, OP_LOCK, OP_UNLOCK: arg_ok = page_in_range;
         OP_GPSET, OP_GPCLR:                    arg_ok = bit_in_range;
         default:                               arg_ok = 1'b1;
      endcase
   end

endmodule

// File: rtl/fcmd_nvm.sv
module fcmd_nvm #(
   parameter int REGIONS  = 8,
   parameter int REGION_W = 3,
   parameter int GP_BITS  = 2,
   parameter int GPI_W    = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lock_set,
   input  logic                lock_clr,
   input  logic [REGION_W-1:0] region,
   input  logic                gp_set,
   input  logic                gp_clr,
   input  logic [GPI_W-1:0]    gp_idx,
   output logic [REGIONS-1:0]  lock_vec,
   output logic [GP_BITS-1:0]  gp_vec
);

   for (genvar r = 0; r < REGIONS; r++) begin : g_lock
      logic hit;
      assign hit = (region == REGION_W'(r));
      always_ff @(posedge clk) begin
         if (!rst_n)              lock_vec[r] <= 1'b0;
         else if (lock_set && hit) lock_vec[r] <= 1'b1;
         else if (lock_clr && hit) lock_vec[r] <= 1'b0;
      end
   end

   for (genvar g = 0; g < GP_BITS; g++) begin : g_gp
      logic hit;
      assign hit = (gp_idx == GPI_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n)             gp_vec[g] <= 1'b0;
         else if (gp_set && hit) gp_vec[g] <= 1'b1;
         else if (gp_clr && hit) gp_vec[g] <= 1'b0;
      end
   end

endmodule

// File: rtl/fcmd_result.sv
module fcmd_result
   import fcmd_pkg::*;
#(
   parameter logic [RES_W-1:0] FLASH_ID = 32'h0F1A_5C01,
   parameter int FLASH_BYTES  = 131072,
   parameter int PAGE_BYTES   = 256,
   parameter int REGIONS      = 8,
   parameter int REGION_BYTES = 16384,
   parameter int GP_BITS      = 2,
   parameter int DESC_WORDS   = 5,
   parameter int PTR_W        = $clog2(DESC_WORDS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  rmode_t             mode_in,
   input  logic               adv,
   input  logic [REGIONS-1:0] lock_vec,
   input  logic [GP_BITS-1:0] gp_vec,
   output logic [PTR_W-1:0]   rd_ptr,
   output logic [RES_W-1:0]   data
);

   localparam logic [PTR_W-1:0] PTR_END = PTR_W'(DESC_WORDS);

   rmode_t     mode_q;
   logic [RES_W-1:0] desc_word;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= RM_NONE;
         rd_ptr <= '0;
      end else if (load) begin
         mode_q <= mode_in;
         rd_ptr <= '0;
      end else if (adv && rd_ptr != PTR_END) begin
         rd_ptr <= rd_ptr + 1'b1;
      end
   end

   always_comb begin
      unique case (rd_ptr)
         PTR_W'(0): desc_word = FLASH_ID;
         PTR_W'(1): desc_word = RES_W'(FLASH_BYTES);
         PTR_W'(2): desc_word = RES_W'(PAGE_BYTES);
         PTR_W'(3): desc_word = RES_W'(REGIONS);
         PTR_W'(4): desc_word = RES_W'(REGION_BYTES);
         default:   desc_word = '0;
      endcase
   end

   always_comb begin
      unique case (mode_q)
         RM_DESC: data = desc_word;
         RM_LOCK: data = (rd_ptr == '0) ? RES_W'(lock_vec) : '0;
         RM_GP:   data = (rd_ptr == '0) ? RES_W'(gp_vec)   : '0;
         default: data = '0;
      endcase
   end

endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl
   import fcmd_pkg::*;
#(
   parameter int               FLASH_KB   = 128,
   parameter int               PAGE_BYTES = 256,
   parameter int               GP_BITS    = 2,
   parameter logic [31:0]      FLASH_ID   = 32'h0F1A_5C01
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_we,
   input  logic [31:0] cmd_word,
   input  logic        res_re,
   output logic [31:0] res_word,
   input  logic        stat_re,
   output logic        ready,
   output logic        lock_err,
   output logic        cmd_err,
   output logic        prog_start,
   output logic        prog_erase,
   output logic [15:0] prog_page,
   input  logic        prog_done,
   output logic        security_en,
   output logic        boot_flash
);

   localparam int FLASH_BYTES  = FLASH_KB * 1024;
   localparam int PAGES        = FLASH_BYTES / PAGE_BYTES;
   localparam int REGIONS      = (FLASH_KB == 128) ? 8 : 16;
   localparam int PPR          = PAGES / REGIONS;
   localparam int PPR_LOG2     = $clog2(PPR);
   localparam int PAGE_W       = $clog2(PAGES);
   localparam int REGION_W     = PAGE_W - PPR_LOG2;
   localparam int REGION_BYTES = PPR * PAGE_BYTES;
   localparam int GPI_W        = (GP_BITS > 1) ? $clog2(GP_BITS) : 1;
   localparam int DESC_WORDS   = 5;
   localparam int PTR_W        = $clog2(DESC_WORDS + 1);

   if (FLASH_KB != 64 && FLASH_KB != 128) begin : g_bad_size
      $error("fcmd_ctrl: FLASH_KB must be 64 or 128");
   end
   if (PAGE_BYTES < 4 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("fcmd_ctrl: PAGE_BYTES must be a power of two");
   end
   if (GP_BITS < 2 || GP_BITS > 32) begin : g_bad_gp
      $error("fcmd_ctrl: GP_BITS must lie in 2..32");
   end
   if (PAGES > 65536 || (1 << REGION_W) != REGIONS) begin : g_bad_map
      $error("fcmd_ctrl: page or region layout does not fit the argument field");
   end

   op_t                 op;
   logic                arg_ok;
   logic [ARG_W-1:0]    arg;
   logic [REGION_W-1:0] region;
   logic [GPI_W-1:0]    gp_idx;
   logic [REGIONS-1:0]  lock_vec;
   logic [GP_BITS-1:0]  gp_vec;
   logic [PTR_W-1:0]    rd_ptr;

   logic   accept, cmd_good, is_prog, region_locked, start_now;
   logic   lock_hit, bad_cmd, busy_q;
   rmode_t next_mode;

   fcmd_decode #(
      .PAGES(PAGES), .PPR_LOG2(PPR_LOG2), .REGION_W(REGION_W),
      .GP_BITS(GP_BITS), .GPI_W(GPI_W)
   ) u_dec (
      .cmd(cmd_word), .op(op), .arg_ok(arg_ok), .arg(arg),
      .region(region), .gp_idx(gp_idx)
   );

   assign accept        = cmd_we && ready;
   assign bad_cmd       = accept && (op == OP_BAD || !arg_ok);
   assign cmd_good      = accept && op != OP_BAD && arg_ok;
   assign is_prog       = (op == OP_PROG) || (op == OP_EPROG);
   assign region_locked = lock_vec[region];
   assign start_now     = cmd_good && is_prog && !region_locked;
   assign lock_hit      = cmd_good && is_prog && region_locked;

   always_comb begin
      unique case (op)
         OP_DESC:    next_mode = RM_DESC;
         OP_GETLOCK: next_mode = RM_LOCK;
         OP_GETGP:   next_mode = RM_GP;
         default:    next_mode = RM_NONE;
      endcase
   end

   fcmd_nvm #(
      .REGIONS(REGIONS), .REGION_W(REGION_W), .GP_BITS(GP_BITS), .GPI_W(GPI_W)
   ) u_nvm (
      .clk(clk), .rst_n(rst_n),
      .lock_set(cmd_good && op == OP_LOCK),
      .lock_clr(cmd_good && op == OP_UNLOCK),
      .region(region),
      .gp_set(cmd_good && op == OP_GPSET),
      .gp_clr(cmd_good && op == OP_GPCLR),
      .gp_idx(gp_idx),
      .lock_vec(lock_vec), .gp_vec(gp_vec)
   );

   fcmd_result #(
      .FLASH_ID(FLASH_ID), .FLASH_BYTES(FLASH_BYTES), .PAGE_BYTES(PAGE_BYTES),
      .REGIONS(REGIONS), .REGION_BYTES(REGION_BYTES), .GP_BITS(GP_BITS),
      .DESC_WORDS(DESC_WORDS), .PTR_W(PTR_W)
   ) u_res (
      .clk(clk), .rst_n(rst_n), .load(cmd_good), .mode_in(next_mode),
      .adv(res_re), .lock_vec(lock_vec), .gp_vec(gp_vec),
      .rd_ptr(rd_ptr), .data(res_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         prog_start <= 1'b0;
         prog_erase <= 1'b0;
         prog_page  <= '0;
         lock_err   <= 1'b0;
         cmd_err    <= 1'b0;
      end else begin
         prog_start <= start_now;
         if (start_now) begin
            busy_q     <= 1'b1;
            prog_erase <= (op == OP_EPROG);
            prog_page  <= arg;
         end else if (prog_done) begin
            busy_q <= 1'b0;
         end
         lock_err <= lock_hit || (lock_err && !stat_re);
         cmd_err  <= bad_cmd  || (cmd_err  && !stat_re);
      end
   end

   assign ready       = !busy_q;
   assign security_en = gp_vec[0];
   assign boot_flash  = gp_vec[1];

endmodule

// File: rtl/fcmd_ctrl_chk.sv
module fcmd_ctrl_chk #(
   parameter int REGIONS  = 8,
   parameter int REGION_W = 3,
   parameter int PPR_LOG2 = 6,
   parameter int GP_BITS  = 2,
   parameter int PTR_W    = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_we,
   input logic               cmd_good,
   input logic               ready,
   input logic               stat_re,
   input logic               lock_err,
   input logic               prog_start,
   input logic [15:0]        prog_page,
   input logic [REGIONS-1:0] lock_vec,
   input logic [GP_BITS-1:0] gp_vec,
   input logic [PTR_W-1:0]   rd_ptr
);

   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |=> !prog_start); // R5

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> !ready); // R5

   AST_START_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> !lock_vec[REGION_W'(prog_page >> PPR_LOG2)]); // R4

   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !ready) |=> ($stable(lock_vec) && $stable(gp_vec))); // R6

   AST_PTR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_good |=> (rd_ptr == '0)); // R7

   AST_LOCKERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_err && !stat_re) |=> lock_err); // R9

endmodule

bind fcmd_ctrl fcmd_ctrl_chk #(
   .REGIONS(REGIONS), .REGION_W(REGION_W), .PPR_LOG2(PPR_LOG2),
   .GP_BITS(GP_BITS), .PTR_W(PTR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_good(cmd_good),
   .ready(ready), .stat_re(stat_re), .lock_err(lock_err),
   .prog_start(prog_start), .prog_page(prog_page),
   .lock_vec(lock_vec), .gp_vec(gp_vec), .rd_ptr(rd_ptr)
);

// File: tb/sim_fcmd_ctrl.sv
module sim_fcmd_ctrl;

   localparam logic [31:0] ID = 32'h0F1A_5C01;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 1'b0;
   logic [31:0] cmd_word = '0;
   logic        res_re = 1'b0;
   logic        stat_re = 1'b0;
   logic        prog_done = 1'b0;

   logic [31:0] res0, res1;
   logic        rdy0, rdy1, le0, le1, ce0, ce1, st0, st1, er0, er1;
   logic [15:0] pg0, pg1;
   logic        sec0, sec1, bt0, bt1;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   fcmd_ctrl #(.FLASH_KB(128), .FLASH_ID(ID)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_word),
      .res_re(res_re), .res_word(res0), .stat_re(stat_re), .ready(rdy0),
      .lock_err(le0), .cmd_err(ce0), .prog_start(st0), .prog_erase(er0),
      .prog_page(pg0), .prog_done(prog_done), .security_en(sec0), .boot_flash(bt0)
   );

   fcmd_ctrl #(.FLASH_KB(64), .FLASH_ID(ID)) u1 (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_word),
      .res_re(res_re), .res_word(res1), .stat_re(stat_re), .ready(rdy1),
      .lock_err(le1), .cmd_err(ce1), .prog_start(st1), .prog_erase(er1),
      .prog_page(pg1), .prog_done(prog_done), .security_en(sec1), .boot_flash(bt1)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_cmd(logic [7:0] code, logic [15:0] arg, logic [7:0] rsvd = 8'h00);
      @(negedge clk);
      cmd_we   = 1'b1;
      cmd_word = {rsvd, arg, code};
      @(negedge clk);
      cmd_we   = 1'b0;
   endtask

   task automatic rd_res(output logic [31:0] w0, output logic [31:0] w1);
      w0 = res0;
      w1 = res1;
      res_re = 1'b1;
      @(negedge clk);
      res_re = 1'b0;
   endtask

   task automatic rd_stat();
      stat_re = 1'b1;
      @(negedge clk);
      stat_re = 1'b0;
   endtask

   task automatic done_pulse();
      prog_done = 1'b1;
      @(negedge clk);
      prog_done = 1'b0;
   endtask

   function automatic logic [31:0] desc_exp(int kb, int idx);
      case (idx)
         0: return ID;
         1: return kb * 1024;
         2: return 256;
         3: return (kb == 128) ? 8 : 16;
         4: return (kb == 128) ? 16384 : 4096;
         default: return 0;
      endcase
   endfunction

   task automatic t_reset();
      @(negedge clk);
      chk("R1 ready u0", {31'b0, rdy0}, 1);
      chk("R1 ready u1", {31'b0, rdy1}, 1);
      chk("R1 flags", {26'b0, le0, le1, ce0, ce1, st0, st1}, 0);
      chk("R1 gp outs", {28'b0, sec0, sec1, bt0, bt1}, 0);
      chk("R1 result u0", res0, 0);
      chk("R1 result u1", res1, 0);
   endtask

   task automatic t_desc();
      logic [31:0] a, b;
      wr_cmd(8'h11, 16'h0);
      for (int i = 0; i < 7; i++) begin
         rd_res(a, b);
         chk($sformatf("R2 desc word %0d u0", i), a, desc_exp(128, i));
         chk($sformatf("R2 desc word %0d u1", i), b, desc_exp(64, i));
      end
      wr_cmd(8'h11, 16'h0);
      rd_res(a, b);
      rd_res(a, b);
      chk("R2 second word u0", a, 131072);
      wr_cmd(8'h11, 16'h0);
      rd_res(a, b);
      chk("R7 restart u0", a, ID);
      chk("R7 restart u1", b, ID);
   endtask

   task automatic t_lock_map();
      logic [31:0] a, b;
      wr_cmd(8'h08, 16'd70);
      wr_cmd(8'h0A, 16'd0);
      rd_res(a, b);
      chk("R3 lock page 70 u0", a, 32'h0000_0002);
      chk("R3 lock page 70 u1", b, 32'h0000_0010);
      wr_cmd(8'h08, 16'd255);
      wr_cmd(8'h0A, 16'd0);
      rd_res(a, b);
      chk("R3 lock page 255 u0", a, 32'h0000_000A);
      chk("R3 lock page 255 u1", b, 32'h0000_8010);
      rd_res(a, b);
      chk("R3 lock word1 u0", a, 0);
      // page 100: region 1 locked on u0, region 6 free on u1
      wr_cmd(8'h01, 16'd100);
      chk("R4 no start u0", {31'b0, st0}, 0);
      chk("R4 ready u0", {31'b0, rdy0}, 1);
      chk("R4 lock_err u0", {31'b0, le0}, 1);
      chk("R5 start u1", {31'b0, st1}, 1);
      chk("R5 page u1", {16'b0, pg1}, 100);
      chk("R5 erase u1", {31'b0, er1}, 0);
      chk("R5 busy u1", {31'b0, rdy1}, 0);
      chk("R4 no lock_err u1", {31'b0, le1}, 0);
      @(negedge clk);
      chk("R5 pulse ends u1", {31'b0, st1}, 0);
      chk("R5 still busy u1", {31'b0, rdy1}, 0);
      done_pulse();
      chk("R5 ready again u1", {31'b0, rdy1}, 1);
      // page 75: region 1 on u0, region 4 on u1, both locked
      wr_cmd(8'h01, 16'd75);
      chk("R4 both rejected", {30'b0, st0, st1}, 0);
      chk("R4 both ready", {30'b0, rdy0, rdy1}, 3);
      chk("R4 lock_err u1", {31'b0, le1}, 1);
   endtask

   task automatic t_status();
      repeat (3) @(negedge clk);
      chk("R9 sticky", {30'b0, le0, le1}, 3);
      rd_stat();
      chk("R9 cleared", {30'b0, le0, le1}, 0);
   endtask

   task automatic t_prog();
      logic [31:0] a, b;
      wr_cmd(8'h09, 16'd70);
      wr_cmd(8'h0A, 16'd0);
      rd_res(a, b);
      chk("R11 unlock u0", a, 32'h0000_0008);
      chk("R11 unlock u1", b, 32'h0000_8000);
      wr_cmd(8'h03, 16'd65);
      chk("R5 start both", {30'b0, st0, st1}, 3);
      chk("R5 erase both", {30'b0, er0, er1}, 3);
      chk("R5 page u0", {16'b0, pg0}, 65);
      chk("R5 page u1", {16'b0, pg1}, 65);
      wr_cmd(8'h08, 16'd0);
      wr_cmd(8'h5E, 16'd0);
      chk("R6 busy both", {30'b0, rdy0, rdy1}, 0);
      chk("R6 no cmd_err", {30'b0, ce0, ce1}, 0);
      done_pulse();
      chk("R5 done both", {30'b0, rdy0, rdy1}, 3);
      wr_cmd(8'h0A, 16'd0);
      rd_res(a, b);
      chk("R6 locks unchanged u0", a, 32'h0000_0008);
      chk("R6 locks unchanged u1", b, 32'h0000_8000);
   endtask

   task automatic t_gp();
      logic [31:0] a, b;
      wr_cmd(8'h0B, 16'd0);
      chk("R10 security on", {30'b0, sec0, sec1}, 3);
      wr_cmd(8'h0B, 16'd1);
      chk("R10 boot on", {30'b0, bt0, bt1}, 3);
      wr_cmd(8'h0C, 16'd0);
      chk("R10 security off", {30'b0, sec0, sec1}, 0);
      wr_cmd(8'h0D, 16'd0);
      rd_res(a, b);
      chk("R10 gp status u0", a, 2);
      chk("R10 gp status u1", b, 2);
      rd_res(a, b);
      chk("R10 gp word1", a | b, 0);
   endtask

   task automatic t_err();
      logic [31:0] a, b;
      wr_cmd(8'h5E, 16'd0);
      chk("R8 unknown code", {30'b0, ce0, ce1}, 3);
      chk("R8 unknown no start", {28'b0, st0, st1, rdy0, rdy1}, 3);
      rd_stat();
      chk("R9 cmd_err cleared", {30'b0, ce0, ce1}, 0);
      wr_cmd(8'h01, 16'd600);
      chk("R8 page range", {30'b0, ce0, ce1}, 3);
      chk("R8 page range no start", {30'b0, st0, st1}, 0);
      rd_stat();
      wr_cmd(8'h0B, 16'd5);
      chk("R8 bit range", {30'b0, ce0, ce1}, 3);
      chk("R8 gp unchanged", {28'b0, sec0, sec1, bt0, bt1}, 3);
      rd_stat();
      wr_cmd(8'h08, 16'd0, 8'h80);
      chk("R8 reserved field", {30'b0, ce0, ce1}, 3);
      wr_cmd(8'h0A, 16'd0);
      rd_res(a, b);
      chk("R8 reserved no lock u0", a, 32'h0000_0008);
      chk("R8 reserved no lock u1", b, 32'h0000_8000);
      rd_stat();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_desc();
      t_lock_map();
      t_status();
      t_prog();
      t_gp();
      t_err();
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule